// File: doc/BRIEF.md
# Cascaded Interrupt Vector Acknowledge Sequencer

This block carries out the processor's interrupt-acknowledge cycle for a pair of interrupt controllers: a master, and a slave whose request output feeds master input line 2. When the processor asks for a vector, the block samples each controller's current winning line and its valid flag. It pulses acknowledge strobes to the controllers that own the interrupt and returns an 8-bit vector number together with a one-cycle done pulse.

Priority resolution inside each controller happens elsewhere. This block only decides who gets acknowledged, in which order, and which vector goes back. It covers a normal master interrupt, an interrupt routed through the cascade line, and a spurious interrupt on either controller. In a spurious case the vector points at line 7 of the controller that found nothing.

Top module: `cascade_ack_seq`

## Requirements
- R1: When the sampled master flag is valid and the master line is not 2, only the master is strobed, with that line. The vector is {master base[7:3], master line}.
- R2: When the master line is 2 and the slave flag is valid, the slave is strobed with its line in the first cycle after acceptance. The master is strobed with line 2 in the second cycle. The vector is {slave base[7:3], slave line}.
- R3: When the master line is 2 and the slave flag is invalid, the slave is never strobed. The master is strobed with line 2 in the second cycle after acceptance. The vector is {slave base[7:3], 3'b111}.
- R4: When the master flag is invalid, no controller is strobed. The vector is {master base[7:3], 3'b111} and appears in the first cycle after acceptance.
- R5: Bits [2:0] of both vector bases never reach the vector.
- R6: Each acknowledge strobe lasts one cycle, and the two strobes are never high in the same cycle. Each strobe's line output is 0 while that strobe is low.
- R7: Done is high for exactly one cycle, the cycle after the last strobe. The vector output is 0 whenever done is low.
- R8: A request is accepted only when the block is idle. Controller inputs are sampled at acceptance only. A request raised during a sequence, and any input change after acceptance, do not affect the strobes or the vector.
- R9: After reset, both strobes, both line outputs, done and the vector are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ack_req | input | 1 | Processor acknowledge request |
| mst_valid | input | 1 | Master has a winning line |
| mst_line | input | 3 | Master winning line |
| slv_valid | input | 1 | Slave has a winning line |
| slv_line | input | 3 | Slave winning line |
| mst_base | input | 8 | Master vector base |
| slv_base | input | 8 | Slave vector base |
| mst_ack | output | 1 | Master acknowledge strobe |
| mst_ack_line | output | 3 | Line acknowledged on the master |
| slv_ack | output | 1 | Slave acknowledge strobe |
| slv_ack_line | output | 3 | Line acknowledged on the slave |
| done | output | 1 | Vector valid pulse |
| vector | output | 8 | Returned vector number |

## Verification
The bench builds the block with its defaults: 3-bit lines, 8-bit vectors and cascade line 2. At these values every master line, including the cascade line, and the all-ones spurious line can be reached directly from stimulus. The vector bases use non-zero low bits, so any leakage of those bits into the vector would show. The stimulus inputs are scrambled right after acceptance, and a second request is raised in the middle of a cascade sequence. This exposes any late sampling or re-triggering.

// File: rtl/cascade_ack_seq.sv
module cascade_ack_seq #(
  parameter int LINE_W       = 3,
  parameter int VEC_W        = 8,
  parameter int CASCADE_LINE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ack_req,
  input  logic              mst_valid,
  input  logic [LINE_W-1:0] mst_line,
  input  logic              slv_valid,
  input  logic [LINE_W-1:0] slv_line,
  input  logic [VEC_W-1:0]  mst_base,
  input  logic [VEC_W-1:0]  slv_base,
  output logic              mst_ack,
  output logic [LINE_W-1:0] mst_ack_line,
  output logic              slv_ack,
  output logic [LINE_W-1:0] slv_ack_line,
  output logic              done,
  output logic [VEC_W-1:0]  vector
);
  localparam logic [LINE_W-1:0] CASC = LINE_W'(CASCADE_LINE);
  localparam logic [LINE_W-1:0] SPUR = '1;

  typedef enum logic [1:0] {S_IDLE, S_SLV, S_MST, S_FIN} state_t;

  state_t            st;
  logic [LINE_W-1:0] m_line_q, s_line_q;
  logic              s_valid_q;
  logic [VEC_W-1:0]  vec_q, vec_d;
  state_t            first_st;

  always_comb begin
    if (!mst_valid) begin
      vec_d    = {mst_base[VEC_W-1:LINE_W], SPUR};
      first_st = S_FIN;
    end else if (mst_line == CASC) begin
      vec_d    = {slv_base[VEC_W-1:LINE_W], slv_valid ? slv_line : SPUR};
      first_st = S_SLV;
    end else begin
      vec_d    = {mst_base[VEC_W-1:LINE_W], mst_line};
      first_st = S_MST;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      m_line_q  <= '0;
      s_line_q  <= '0;
      s_valid_q <= 1'b0;
      vec_q     <= '0;
    end else begin
      case (st)
        S_IDLE: if (ack_req) begin
          st        <= first_st;
          m_line_q  <= mst_line;
          s_line_q  <= slv_line;
          s_valid_q <= slv_valid;
          vec_q     <= vec_d;
        end
        S_SLV:   st <= S_MST;
        S_MST:   st <= S_FIN;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign slv_ack      = (st == S_SLV) && s_valid_q;
  assign slv_ack_line = slv_ack ? s_line_q : '0;
  assign mst_ack      = (st == S_MST);
  assign mst_ack_line = mst_ack ? m_line_q : '0;
  assign done         = (st == S_FIN);
  assign vector       = done ? vec_q : '0;
endmodule

module cascade_ack_seq_chk #(
  parameter int LINE_W       = 3,
  parameter int VEC_W        = 8,
  parameter int CASCADE_LINE = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mst_ack,
  input logic [LINE_W-1:0] mst_ack_line,
  input logic              slv_ack,
  input logic [LINE_W-1:0] slv_ack_line,
  input logic              done,
  input logic [VEC_W-1:0]  vector
);
  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(mst_ack && slv_ack));
  assert_mst_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mst_ack |=> !mst_ack);
  assert_slv_line_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !slv_ack |-> slv_ack_line == '0);
  assert_slv_then_mst_R2: assert property (@(posedge clk) disable iff (!rst_n)
    slv_ack |=> mst_ack && mst_ack_line == LINE_W'(CASCADE_LINE));
  assert_done_after_mst_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mst_ack |=> done);
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_vec_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> vector == '0);
endmodule

bind cascade_ack_seq cascade_ack_seq_chk #(
  .LINE_W(LINE_W), .VEC_W(VEC_W), .CASCADE_LINE(CASCADE_LINE)
) chk_i (
  .clk(clk), .rst_n(rst_n), .mst_ack(mst_ack), .mst_ack_line(mst_ack_line),
  .slv_ack(slv_ack), .slv_ack_line(slv_ack_line), .done(done), .vector(vector)
);

// File: tb/cascade_ack_seq_tb_top.sv
module cascade_ack_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ack_req = 1'b0;
  logic mst_valid = 1'b0, slv_valid = 1'b0;
  logic [2:0] mst_line = '0, slv_line = '0;
  logic [7:0] mst_base = '0, slv_base = '0;
  logic mst_ack, slv_ack, done;
  logic [2:0] mst_ack_line, slv_ack_line;
  logic [7:0] vector;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  cascade_ack_seq dut_i (
    .clk(clk), .rst_n(rst_n), .ack_req(ack_req),
    .mst_valid(mst_valid), .mst_line(mst_line),
    .slv_valid(slv_valid), .slv_line(slv_line),
    .mst_base(mst_base), .slv_base(slv_base),
    .mst_ack(mst_ack), .mst_ack_line(mst_ack_line),
    .slv_ack(slv_ack), .slv_ack_line(slv_ack_line),
    .done(done), .vector(vector)
  );

  // {mst_valid, mst_line, slv_valid, slv_line, mst_base, slv_base}
  localparam int NV = 11;
  localparam logic [23:0] VECS [NV] = '{
    {1'b1, 3'd0, 1'b0, 3'd0, 8'h08, 8'h70},
    {1'b1, 3'd5, 1'b1, 3'd3, 8'h0F, 8'h70},
    {1'b1, 3'd7, 1'b0, 3'd1, 8'hA5, 8'h33},
    {1'b1, 3'd1, 1'b1, 3'd6, 8'h20, 8'h28},
    {1'b1, 3'd2, 1'b1, 3'd0, 8'h08, 8'h70},
    {1'b1, 3'd2, 1'b1, 3'd6, 8'h1B, 8'h77},
    {1'b1, 3'd2, 1'b1, 3'd7, 8'h40, 8'hC9},
    {1'b1, 3'd2, 1'b0, 3'd4, 8'h08, 8'h76},
    {1'b1, 3'd2, 1'b0, 3'd0, 8'h5F, 8'hE1},
    {1'b0, 3'd2, 1'b1, 3'd4, 8'h0E, 8'h70},
    {1'b0, 3'd3, 1'b0, 3'd0, 8'hF7, 8'h11}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Runs one acknowledge and checks four cycles after acceptance.
  // busy=1 raises a second request in cycle 1 with different inputs.
  task automatic run_case(input logic [23:0] v, input bit busy);
    logic mv, sv;
    logic [2:0] ml, sl, exp_line;
    logic [7:0] mb, sb, exp_vec;
    int es, em, ed;
    string tag;
    {mv, ml, sv, sl, mb, sb} = v;
    es = 0; em = 0;
    if (!mv) begin
      ed = 1; exp_vec = {mb[7:3], 3'd7}; tag = "R4";
    end else if (ml == 3'd2) begin
      em = 2; ed = 3;
      if (sv) begin es = 1; exp_vec = {sb[7:3], sl}; tag = "R2"; end
      else begin exp_vec = {sb[7:3], 3'd7}; tag = "R3"; end
    end else begin
      em = 1; ed = 2; exp_vec = {mb[7:3], ml}; tag = "R1";
    end
    if (busy) tag = {tag, "/R8"};
    @(negedge clk);
    mst_valid = mv; mst_line = ml; slv_valid = sv; slv_line = sl;
    mst_base = mb; slv_base = sb; ack_req = 1'b1;
    @(negedge clk);
    ack_req = busy;
    mst_valid = ~mv; mst_line = ~ml; slv_valid = ~sv; slv_line = ~sl;
    mst_base = ~mb; slv_base = ~sb;
    for (int c = 1; c <= 4; c++) begin
      if (c > 1) begin
        @(negedge clk);
        ack_req = 1'b0;
      end
      chk(slv_ack == (c == es), {tag, " slv_ack"}, slv_ack, c == es);
      chk(mst_ack == (c == em), {tag, " mst_ack"}, mst_ack, c == em);
      chk(done == (c == ed), {tag, " R7 done"}, done, c == ed);
      exp_line = (c == es) ? sl : 3'd0;
      chk(slv_ack_line == exp_line, {tag, " R6 slv_line"}, slv_ack_line, exp_line);
      exp_line = (c == em) ? ml : 3'd0;
      chk(mst_ack_line == exp_line, {tag, " R6 mst_line"}, mst_ack_line, exp_line);
      chk(vector == ((c == ed) ? exp_vec : 8'h00), {tag, " R5 vector"}, vector,
          (c == ed) ? exp_vec : 8'h00);
    end
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_fail++;
        n_run++;
        $display("FAIL watchdog actual=%0d expected=<100000", cyc);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!mst_ack && !slv_ack && !done, "R9 strobes/done", {mst_ack, slv_ack, done}, 0);
    chk(vector == 8'h00 && mst_ack_line == 3'd0 && slv_ack_line == 3'd0,
        "R9 vector/lines", vector, 0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) run_case(VECS[i], 1'b0);
    run_case({1'b1, 3'd2, 1'b1, 3'd5, 8'h08, 8'h70}, 1'b1);
    run_case({1'b1, 3'd2, 1'b0, 3'd5, 8'h08, 8'h70}, 1'b1);
    run_case({1'b1, 3'd4, 1'b0, 3'd0, 8'h08, 8'h70}, 1'b1);
    run_case({1'b0, 3'd0, 1'b0, 3'd0, 8'h08, 8'h70}, 1'b0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule